// File: doc/BRIEF.md
# Byte Input Port with Flag-Released Handshake

This block sits between a slow byte-wide peripheral and a processor. The peripheral drives a byte and raises a valid line. The port captures the byte into a holding register and raises an accepted line. It also sets a status flag that the processor can poll or take as an interrupt. The accepted line stays high until the processor clears the flag, and only then does it fall. Clearing the flag is therefore what lets the peripheral send its next byte.

A configuration input chooses how the flag is cleared. It is cleared either by an explicit clear strobe or as a side effect of reading the data register. The valid line is asynchronous and passes through a two-flop synchronizer. A byte is taken only on a rising edge of the synchronized valid. A valid line that is still high when the flag clears therefore never delivers the same byte twice.

Top module: `byte_in_port`

## Requirements
- R1: While rst_ni is low and just after it rises, dev_accept_o, flag_o and irq_o are 0 and rd_data_o is 8'h00.
- R2: After dev_valid_i rises in an idle port, the third rising clock edge loads dev_data_i into rd_data_o and sets both flag_o and dev_accept_o to 1. After the second edge, flag_o is still 0.
- R3: While dev_accept_o is 1, a new rising edge on dev_valid_i with different data leaves rd_data_o and flag_o unchanged.
- R4: With auto_clr_i = 0, a clr_wr_i pulse sampled while flag_o = 1 clears flag_o at that edge. rd_en_i alone does not clear it.
- R5: With auto_clr_i = 1, an rd_en_i pulse sampled while flag_o = 1 clears flag_o at that edge. clr_wr_i alone does not clear it.
- R6: dev_accept_o falls exactly one clock after flag_o falls, and never while flag_o is 1.
- R7: If dev_valid_i is still high when dev_accept_o falls, no byte is captured until dev_valid_i has gone low and risen again.
- R8: irq_o is 1 exactly when irq_en_i is 1 and flag_o is 1. It follows irq_en_i within the same cycle.
- R9: rd_data_o changes only in the cycle in which flag_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_data_i | input | 8 | Byte from the peripheral |
| dev_valid_i | input | 1 | Peripheral byte-present line (asynchronous) |
| dev_accept_o | output | 1 | Byte taken; held until the flag is cleared |
| rd_en_i | input | 1 | Processor read strobe for the data register |
| rd_data_o | output | 8 | Data register contents |
| flag_o | output | 1 | Status flag: byte waiting |
| clr_wr_i | input | 1 | Processor write strobe that clears the flag |
| auto_clr_i | input | 1 | 1: read clears the flag, 0: write clears it |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
A processor data read and a processor clear write can land in the same cycle. Only the strobe that the selected clear mode names may clear the flag. The bench pulses rd_en_i and clr_wr_i together, and also each one alone, in both modes. It then samples flag_o and dev_accept_o on the following half-cycles. A lone strobe of the wrong kind must leave the flag set, and the joint pulse must clear it and release the accepted line one clock later.

// File: rtl/in_port_pkg.sv
package in_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FULL    = 2'd1,
    ST_RELEASE = 2'd2
  } port_state_e;
endpackage

// File: rtl/in_port_sync.sv
module in_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/in_port_ctrl.sv
module in_port_ctrl
  import in_port_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_s_i,
  input  logic auto_clr_i,
  input  logic rd_en_i,
  input  logic clr_wr_i,
  output logic cap_o,
  output logic flag_o,
  output logic accept_o
);
  port_state_e state_q, state_d;
  logic        valid_d_q;
  logic        rise;
  logic        clr_req;

  assign rise    = valid_s_i & ~valid_d_q;
  assign clr_req = auto_clr_i ? rd_en_i : clr_wr_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (rise) state_d = ST_FULL;
      ST_FULL:    if (clr_req) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      valid_d_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      valid_d_q <= valid_s_i;
    end
  end

  // capture only from idle, on a fresh edge
  assign cap_o    = (state_q == ST_IDLE) & rise;
  assign flag_o   = (state_q == ST_FULL);
  assign accept_o = (state_q != ST_IDLE);
endmodule

// File: rtl/in_port_dreg.sv
module in_port_dreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/byte_in_port.sv
module byte_in_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] dev_data_i,
  input  logic              dev_valid_i,
  output logic              dev_accept_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              flag_o,
  input  logic              clr_wr_i,
  input  logic              auto_clr_i,
  input  logic              irq_en_i,
  output logic              irq_o
);
  logic valid_s;
  logic cap;

  in_port_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dev_valid_i),
    .q_o   (valid_s)
  );

  in_port_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_s_i (valid_s),
    .auto_clr_i(auto_clr_i),
    .rd_en_i   (rd_en_i),
    .clr_wr_i  (clr_wr_i),
    .cap_o     (cap),
    .flag_o    (flag_o),
    .accept_o  (dev_accept_o)
  );

  in_port_dreg #(.W(DATA_W)) i_dreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (cap),
    .d_i   (dev_data_i),
    .q_o   (rd_data_o)
  );

  assign irq_o = irq_en_i & flag_o;
endmodule

// File: rtl/byte_in_port_chk.sv
module byte_in_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_accept_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              flag_o,
  input logic              clr_wr_i,
  input logic              auto_clr_i,
  input logic              irq_en_i,
  input logic              irq_o
);
  AST_FLAG_WITH_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $rose(dev_accept_o)); // R2
  AST_CAPTURE_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> !$past(dev_accept_o)); // R3
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !auto_clr_i && clr_wr_i |=> !flag_o); // R4
  AST_WR_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !auto_clr_i && !clr_wr_i |=> flag_o); // R4
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && auto_clr_i && rd_en_i |=> !flag_o); // R5
  AST_RD_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && auto_clr_i && !rd_en_i |=> flag_o); // R5
  AST_ACCEPT_OUTLIVES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> dev_accept_o); // R6
  AST_ACCEPT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |=> !dev_accept_o); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R8
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(flag_o) |-> $stable(rd_data_o)); // R9
endmodule

bind byte_in_port byte_in_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_accept_o(dev_accept_o),
  .rd_en_i     (rd_en_i),
  .rd_data_o   (rd_data_o),
  .flag_o      (flag_o),
  .clr_wr_i    (clr_wr_i),
  .auto_clr_i  (auto_clr_i),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o)
);

// File: tb/test_byte_in_port.sv
module test_byte_in_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_data = 8'h00;
  logic       dev_valid = 1'b0;
  logic       dev_accept;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       flag;
  logic       clr_wr = 1'b0;
  logic       auto_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq;
  int         checks = 0;
  int         failures = 0;

  always #5 clk = ~clk;

  byte_in_port i_byte_in_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dev_data_i  (dev_data),
    .dev_valid_i (dev_valid),
    .dev_accept_o(dev_accept),
    .rd_en_i     (rd_en),
    .rd_data_o   (rd_data),
    .flag_o      (flag),
    .clr_wr_i    (clr_wr),
    .auto_clr_i  (auto_clr),
    .irq_en_i    (irq_en),
    .irq_o       (irq)
  );

  // {auto_clr, irq_en, byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'hFF},
    {1'b1, 1'b1, 8'h01}, {1'b0, 1'b0, 8'h80}, {1'b1, 1'b1, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise valid with byte b; checks latency (R2)
  task automatic send(input logic [7:0] b);
    dev_data  = b;
    dev_valid = 1'b1;
    cyc(2);
    chk("R2 flag not yet", {31'd0, flag}, 32'd0);
    cyc(1);
    chk("R2 flag", {31'd0, flag}, 32'd1);
    chk("R2 accept", {31'd0, dev_accept}, 32'd1);
    chk("R2 data", {24'd0, rd_data}, {24'd0, b});
  endtask

  task automatic drop_valid();
    dev_valid = 1'b0;
    cyc(3);
  endtask

  task automatic pulse(input logic use_rd, input logic use_wr);
    rd_en  = use_rd;
    clr_wr = use_wr;
    cyc(1);
    rd_en  = 1'b0;
    clr_wr = 1'b0;
  endtask

  // clear flag and check release timing (R6)
  task automatic clear_and_release(input logic use_rd, input logic use_wr, input string req);
    pulse(use_rd, use_wr);
    chk(req, {31'd0, flag}, 32'd0);
    chk("R6 accept held", {31'd0, dev_accept}, 32'd1);
    cyc(1);
    chk("R6 accept released", {31'd0, dev_accept}, 32'd0);
  endtask

  initial begin
    cyc(2);
    chk("R1 accept", {31'd0, dev_accept}, 32'd0);
    chk("R1 flag", {31'd0, flag}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 data", {24'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after release", {30'd0, dev_accept, flag}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      auto_clr = VEC[i][9];
      irq_en   = VEC[i][8];
      send(VEC[i][7:0]);
      chk("R8 irq set", {31'd0, irq}, {31'd0, VEC[i][8]});
      drop_valid();
      chk("R4 R5 flag holds", {31'd0, flag}, 32'd1);
      if (VEC[i][9]) clear_and_release(1'b1, 1'b0, "R5 read clears");
      else           clear_and_release(1'b0, 1'b1, "R4 write clears");
      chk("R8 irq clear", {31'd0, irq}, 32'd0);
      chk("R9 data kept", {24'd0, rd_data}, {24'd0, VEC[i][7:0]});
    end

    // wrong strobe per mode ignored, joint strobe clears
    irq_en = 1'b0;
    auto_clr = 1'b0;
    send(8'h42);
    drop_valid();
    pulse(1'b1, 1'b0);
    cyc(1);
    chk("R4 read ignored", {31'd0, flag}, 32'd1);
    clear_and_release(1'b1, 1'b1, "R4 joint clears");
    cyc(2);
    auto_clr = 1'b1;
    send(8'h24);
    drop_valid();
    pulse(1'b0, 1'b1);
    cyc(1);
    chk("R5 write ignored", {31'd0, flag}, 32'd1);
    chk("R5 accept held", {31'd0, dev_accept}, 32'd1);
    clear_and_release(1'b1, 1'b1, "R5 joint clears");
    cyc(2);

    // new edge while full is ignored; stays high past clear (R3, R7)
    auto_clr = 1'b0;
    send(8'h11);
    drop_valid();
    dev_data  = 8'h22;
    dev_valid = 1'b1;
    cyc(5);
    chk("R3 data unchanged", {24'd0, rd_data}, 32'h11);
    chk("R3 flag held", {31'd0, flag}, 32'd1);
    clear_and_release(1'b0, 1'b1, "R4 write clears");
    cyc(6);
    chk("R7 no recapture flag", {31'd0, flag}, 32'd0);
    chk("R7 no recapture accept", {31'd0, dev_accept}, 32'd0);
    chk("R7 data unchanged", {24'd0, rd_data}, 32'h11);
    drop_valid();
    send(8'h22);
    drop_valid();

    // irq follows enable combinationally (R8)
    chk("R8 masked", {31'd0, irq}, 32'd0);
    irq_en = 1'b1;
    #1;
    chk("R8 enabled", {31'd0, irq}, 32'd1);
    irq_en = 1'b0;
    #1;
    chk("R8 re-masked", {31'd0, irq}, 32'd0);
    clear_and_release(1'b0, 1'b1, "R4 write clears");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule